// File: doc/BRIEF.md
# Soft Reset and Write Gating Controller

This block owns the soft-reset control register of a host-attached device and the host configuration override register. A host write that sets the soft-reset bit puts the device's internal core into reset. The block synchronises that request into the core clock domain and stretches it so the core always sees a reset of a guaranteed minimum length.

While soft reset is active, the block acts as a gate on the register write port coming from the access bridge. It accepts writes only to its own two registers and drops every other write. It reports its decision for each write on a per-write accepted flag, which downstream register files use as their write enable.

The override register replaces the strap-pin configuration defaults once it has been written. This lets the host change the core's configuration while the core is held in soft reset. A power-on reset clears everything and returns the configuration to the straps. A host-interface reset releases soft reset but keeps the override. The block keeps no read-only configuration state of its own, so soft reset leaves that state alone.

Top module: `srst_gate`

## Requirements
- R1: After power-on reset is released, the control register reads 0x00000000, the effective configuration follows the strap pins, and the core reset output is low within 6 core clock cycles.
- R2: A write to offset 0x4C with data bit 7 set makes the control register read exactly 0x00000080 on the next cycle. All bits other than bit 7 read as zero, whatever value was written.
- R3: A write to offset 0x4C with data bit 7 clear releases soft reset, and the control register then reads 0x00000000.
- R4: While soft reset is active, a write to any offset other than 0x4C and 0x50 has its accepted flag low in the same cycle, and it does not change the control register.
- R5: While soft reset is inactive, every write has its accepted flag high in the same cycle.
- R6: The effective configuration equals the strap pins until offset 0x50 is written. After that it equals bits [STRAP_W-1:0] of the last data written to 0x50, and later strap changes have no effect. Offset 0x50 reads back the effective configuration, zero-extended.
- R7: While soft reset is active, a write to 0x50 is accepted and updates the effective configuration.
- R8: The core reset output goes high within 4 core clock cycles after the soft-reset bit is set. Once high, it stays high for at least 2 core cycles. It goes low within 6 core cycles after the bit is cleared.
- R9: A host-interface reset clears the soft-reset bit and keeps the override value. Only power-on reset returns the effective configuration to the strap pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side register clock |
| core_clk | input | 1 | Core clock domain |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| host_rst_n | input | 1 | Host-interface reset, active low, asynchronous |
| strap | input | STRAP_W | Strap-pin configuration defaults |
| wr_en | input | 1 | Register write strobe from the access bridge |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read offset |
| rd_data | output | DATA_W | Read data for this block's registers, zero for other offsets |
| wr_accept | output | 1 | Write of this cycle accepted |
| cfg_out | output | STRAP_W | Effective configuration |
| core_srst | output | 1 | Soft reset to the core, core clock domain |

## Verification
The assertions assume that the write strobe, address and data are stable around the host clock edge. They also assume that a soft-reset request stays set for at least two core clock periods, because a shorter request may never reach the synchroniser. The bench drives every host input on the falling edge of the host clock. It holds each soft-reset request for several host cycles, including the shortest case, which it holds for three host cycles against a slower core clock. The bench changes the reset inputs only while no write is in progress.

// File: rtl/srst_gate.sv
module srst_gate #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STRAP_W  = 8,
  parameter int CTRL_OFF = 8'h4C,
  parameter int HCFG_OFF = 8'h50,
  parameter int SRST_BIT = 7,
  parameter int MIN_CYC  = 2
) (
  input  logic               clk,
  input  logic               core_clk,
  input  logic               por_n,
  input  logic               host_rst_n,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               wr_accept,
  output logic [STRAP_W-1:0] cfg_out,
  output logic               core_srst
);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] HcfgA = ADDR_W'(HCFG_OFF);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic               srst_q;
  logic               ovr_vld;
  logic [STRAP_W-1:0] ovr_val;
  logic [1:0]         sync_q;
  logic [CW-1:0]      hold_cnt;
  logic               host_clr_n;
  logic               unused_ok;

  assign host_clr_n = por_n & host_rst_n;
  assign unused_ok  = ^wr_data;

  assign wr_accept = wr_en & (~srst_q | wr_addr == CtrlA | wr_addr == HcfgA);

  always_ff @(posedge clk or negedge host_clr_n)
    if (!host_clr_n)                    srst_q <= 1'b0;
    else if (wr_en && wr_addr == CtrlA) srst_q <= wr_data[SRST_BIT];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      ovr_vld <= 1'b0;
      ovr_val <= '0;
    end else if (wr_en && wr_addr == HcfgA) begin
      ovr_vld <= 1'b1;
      ovr_val <= wr_data[STRAP_W-1:0];
    end

  assign cfg_out = ovr_vld ? ovr_val : strap;

  always_comb begin
    rd_data = '0;
    if (rd_addr == CtrlA)      rd_data[SRST_BIT]    = srst_q;
    else if (rd_addr == HcfgA) rd_data[STRAP_W-1:0] = cfg_out;
  end

  always_ff @(posedge core_clk or negedge por_n)
    if (!por_n) begin
      sync_q   <= 2'b11;
      hold_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], srst_q};
      if (sync_q[1])           hold_cnt <= CW'(MIN_CYC - 1);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

  assign core_srst = sync_q[1] | (hold_cnt != '0);
endmodule

module srst_gate_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STRAP_W  = 8,
  parameter int CTRL_OFF = 8'h4C,
  parameter int HCFG_OFF = 8'h50,
  parameter int SRST_BIT = 7
) (
  input logic               clk,
  input logic               core_clk,
  input logic               por_n,
  input logic               host_rst_n,
  input logic [STRAP_W-1:0] strap,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               wr_accept,
  input logic               srst_q,
  input logic               ovr_vld,
  input logic [STRAP_W-1:0] cfg_out,
  input logic               core_srst
);
  logic ctrl_wr, hcfg_wr;
  assign ctrl_wr = wr_en && wr_addr == ADDR_W'(CTRL_OFF);
  assign hcfg_wr = wr_en && wr_addr == ADDR_W'(HCFG_OFF);

  p_set_r2: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    ctrl_wr && wr_data[SRST_BIT] |=> srst_q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    ctrl_wr && !wr_data[SRST_BIT] |=> !srst_q);
  p_drop_r4: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    srst_q && wr_en && !ctrl_wr && !hcfg_wr |-> !wr_accept);
  p_keep_r4: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    srst_q && !ctrl_wr |=> srst_q);
  p_open_r5: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    !srst_q && wr_en |-> wr_accept);
  p_straps_r6: assert property (@(posedge clk) disable iff (!por_n)
    !ovr_vld && !hcfg_wr |=> cfg_out == strap);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    ovr_vld && !hcfg_wr |=> $stable(cfg_out));
  p_hcfg_r7: assert property (@(posedge clk) disable iff (!(por_n && host_rst_n))
    hcfg_wr |-> wr_accept);
  p_min_pulse_r8: assert property (@(posedge core_clk) disable iff (!por_n)
    $rose(core_srst) |=> core_srst);
endmodule

bind srst_gate srst_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W),
  .CTRL_OFF(CTRL_OFF), .HCFG_OFF(HCFG_OFF), .SRST_BIT(SRST_BIT)
) chk_i (
  .clk(clk), .core_clk(core_clk), .por_n(por_n), .host_rst_n(host_rst_n),
  .strap(strap), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_accept(wr_accept), .srst_q(srst_q), .ovr_vld(ovr_vld),
  .cfg_out(cfg_out), .core_srst(core_srst)
);

// File: tb/srst_gate_tb_top.sv
`timescale 1ns/1ps
module srst_gate_tb_top;
  logic clk = 0, core_clk = 0;
  logic por_n = 0, host_rst_n = 1;
  logic [7:0]  strap = 8'h5A;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wr_accept, core_srst;
  logic [7:0]  cfg_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  always #15 core_clk = ~core_clk;

  srst_gate dut_i (
    .clk(clk), .core_clk(core_clk), .por_n(por_n), .host_rst_n(host_rst_n),
    .strap(strap), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_accept(wr_accept),
    .cfg_out(cfg_out), .core_srst(core_srst)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic exp_acc, string req);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    #1 check(req, 32'(wr_accept), 32'(exp_acc));
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    rd_addr = a;
    #1 check(req, rd_data, exp);
  endtask

  task automatic core_wait(int n);
    repeat (n) @(negedge core_clk);
  endtask

  task automatic t_reset;
    rd(8'h4C, 32'h0, "R1 ctrl after por");
    check("R1 cfg follows straps", 32'(cfg_out), 32'h5A);
    strap = 8'h3C;
    #1 check("R1 cfg tracks strap change", 32'(cfg_out), 32'h3C);
    core_wait(6);
    check("R1 core reset low", 32'(core_srst), 32'h0);
  endtask

  task automatic t_open_writes;
    wr(8'h10, 32'h1234, 1'b1, "R5 accept 0x10");
    wr(8'h88, 32'h0, 1'b1, "R5 accept 0x88");
    check("R5 no override from other write", 32'(cfg_out), 32'h3C);
  endtask

  task automatic t_enter;
    wr(8'h4C, 32'hFFFF_FFFF, 1'b1, "R2 ctrl write accepted");
    rd(8'h4C, 32'h80, "R2 only bit7 reads back");
    core_wait(4);
    check("R8 core reset asserted", 32'(core_srst), 32'h1);
  endtask

  task automatic t_gating;
    wr(8'h10, 32'h0, 1'b0, "R4 drop 0x10");
    wr(8'h4D, 32'h0, 1'b0, "R4 drop 0x4D");
    wr(8'hFF, 32'h0, 1'b0, "R4 drop 0xFF");
    rd(8'h4C, 32'h80, "R4 ctrl unchanged by dropped writes");
    wr(8'h50, 32'hFFFF_FFA3, 1'b1, "R7 hcfg accepted in soft reset");
    check("R7 cfg overridden", 32'(cfg_out), 32'hA3);
    rd(8'h50, 32'hA3, "R6 hcfg readback");
  endtask

  task automatic t_release;
    wr(8'h4C, 32'h7F, 1'b1, "R3 ctrl clear accepted");
    rd(8'h4C, 32'h0, "R3 ctrl reads zero");
    core_wait(6);
    check("R8 core reset released", 32'(core_srst), 32'h0);
    wr(8'h20, 32'h0, 1'b1, "R5 accept after release");
  endtask

  task automatic t_override;
    strap = 8'h11;
    #1 check("R6 strap change ignored", 32'(cfg_out), 32'hA3);
    wr(8'h50, 32'h5, 1'b1, "R6 second override write");
    check("R6 new override", 32'(cfg_out), 32'h05);
  endtask

  task automatic t_short_pulse;
    int hi = 0;
    fork
      begin
        @(negedge clk); wr_en = 1; wr_addr = 8'h4C; wr_data = 32'h80;
        @(negedge clk); wr_en = 0;
        @(negedge clk);
        @(negedge clk); wr_en = 1; wr_data = 32'h0;
        @(negedge clk); wr_en = 0;
      end
      begin
        repeat (14) begin
          @(negedge core_clk);
          if (core_srst) hi++;
        end
      end
    join
    checks++;
    if (hi < 2) begin
      errors++;
      $display("FAIL R8 min pulse: actual=%0d expected>=2", hi);
    end
    check("R8 short pulse ends", 32'(core_srst), 32'h0);
  endtask

  task automatic t_resets;
    wr(8'h4C, 32'h80, 1'b1, "R9 set before host reset");
    @(negedge clk); host_rst_n = 0;
    @(negedge clk); host_rst_n = 1;
    rd(8'h4C, 32'h0, "R9 host reset clears ctrl");
    check("R9 override survives host reset", 32'(cfg_out), 32'h05);
    wr(8'h10, 32'h0, 1'b1, "R9 writes open after host reset");
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    check("R9 por returns straps", 32'(cfg_out), 32'h11);
    rd(8'h50, 32'h11, "R9 hcfg reads straps after por");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        por_n = 1;
        t_reset();
        t_open_writes();
        t_enter();
        t_gating();
        t_release();
        t_override();
        t_short_pulse();
        t_resets();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule